// File: doc/BRIEF.md
# Multi-Rail Power-Good Combiner with Fault Capture

This block turns the status of several regulator rails into one power-good pin. For each rail it takes the enable, the sequencing state, the undervoltage and overvoltage comparator results, a current-limit flag and a pending-interrupt flag. A qualifier decides whether the rail counts as good right now, and a per-rail debounce filter turns that raw verdict into a filtered one. The pin is active only when every filtered verdict is good.

A fault register keeps one bit per rail. It marks each rail whose filtered status went bad. A host read strobe clears the bits of rails that have recovered. Bits of rails that are still bad stay set. In the optional sticky mode the pin stays inactive until every fault bit has been read out. Configuration inputs select the voltage window, the active polarity, the drive type (push-pull or open-drain) and the length of the good-going delay. Filter lengths are clock-cycle counts set by parameters.

Top module: `pg_aggregator`

## Requirements
- R1: The 2-bit monitor select of a rail sets its mode. 00 excludes the rail, so it always counts as good. 01 checks voltage only and ignores the current-limit flag. 10 and 11 check voltage and also require the current-limit flag to be low.
- R2: With the window bit at 0, only undervoltage makes a regulating rail bad. With the window bit at 1, undervoltage or overvoltage makes it bad.
- R3: The state code sets what a monitored, enabled rail contributes. Codes 0 (start-up delay), 1 (soft start), 2 (ramp-up) and 4 (ramp to a new target) are bad. Code 3 (regulating) follows the comparators. Codes 5 (shutdown delay) and 6 (ramp-down) are good. Code 7 (fault-disabled) is good only when no interrupt is pending.
- R4: A monitored rail with enable low counts as good. The exception is state 7 with its interrupt pending, which counts as bad whether or not the rail is enabled.
- R5: The pin is active only when the filtered status of every rail is good.
- R6: A rail's filtered status goes bad only after its raw status has been bad at FALL_CYC consecutive clock edges. A good raw sample in between restarts the count.
- R7: A rail's filtered status goes good after its raw status has been good at RISE_SHORT consecutive edges when the long-delay bit is 0, or at RISE_LONG edges when it is 1.
- R8: A rail's fault bit is set at the clock edge after its filtered status is bad. It stays set until a read strobe.
- R9: A read strobe clears, at the next edge, every fault bit whose rail's filtered status is good. Bits of rails that are still bad stay set.
- R10: With the sticky bit at 1, the pin is inactive while any fault bit is set, even when every rail is good.
- R11: The polarity bit at 1 makes the active level high, and at 0 makes it low. In push-pull mode the output enable is always 1 and the pin carries the level. In open-drain mode the data is 0, and the output enable is 1 only when the level is low.
- R12: During and after reset every filtered status is good and every fault bit is clear, so the pin shows the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_en | input | N_RAIL | Per-rail enable |
| rail_state | input | N_RAIL x 3 | Per-rail sequencing state code |
| mon_sel | input | N_RAIL x 2 | Per-rail monitor select |
| uv_flag | input | N_RAIL | Undervoltage comparator output |
| ov_flag | input | N_RAIL | Overvoltage comparator output |
| ilim_flag | input | N_RAIL | Current-limit active |
| irq_pend | input | N_RAIL | Protection interrupt still pending |
| cfg_window | input | 1 | 1 = check overvoltage as well |
| cfg_pol | input | 1 | 1 = active-high pin |
| cfg_od | input | 1 | 1 = open-drain drive |
| cfg_long_dly | input | 1 | 1 = long good-going delay |
| cfg_sticky | input | 1 | 1 = hold inactive while fault bits are set |
| flt_rd | input | 1 | Host read strobe for the fault register |
| flt_bits | output | N_RAIL | Fault register contents |
| pg_pin | output | 1 | Power-good data out |
| pg_oe | output | 1 | Power-good output enable |

## Verification
The bench first applies directed patterns. These are comparator pulses one cycle shorter than the fall filter and pulses that just reach it, which separate a correct debounce count from one that is off by one. Overvoltage is applied with each window setting, and a current limit is applied under each monitor code. A rail is disabled in a plain state and in a fault state with its interrupt pending. Reads are issued while a rail is still bad, and again after it has recovered, with sticky mode on and off. These tell apart masking, mode decoding and clear-on-read from a simple OR of flags. Every polarity and drive combination is applied to the pin. A long constrained-random phase then changes one rail field at a time, plus occasional configuration changes and reads, against a cycle model kept in the bench. Because of the debounce, the combined AND is exercised with faults that overlap and faults that are staggered.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [2:0] {
        RS_START_DLY = 3'd0,
        RS_SOFT      = 3'd1,
        RS_RAMP_UP   = 3'd2,
        RS_REGULATE  = 3'd3,
        RS_RETARGET  = 3'd4,
        RS_SHUT_DLY  = 3'd5,
        RS_RAMP_DOWN = 3'd6,
        RS_FAULT_OFF = 3'd7
    } rail_state_e;

    typedef enum logic [1:0] {
        MON_NONE = 2'd0,
        MON_VOLT = 2'd1,
        MON_VI_A = 2'd2,
        MON_VI_B = 2'd3
    } mon_sel_e;

endpackage

// File: rtl/pg_rail_qual.sv
module pg_rail_qual
    import pg_pkg::*;
(
    input  logic       en,
    input  logic [2:0] state,
    input  logic [1:0] sel,
    input  logic       uv,
    input  logic       ov,
    input  logic       ilim,
    input  logic       irq,
    input  logic       win,
    output logic       good
);
    rail_state_e st;
    mon_sel_e    mode;
    logic        volt_ok;
    logic        cur_ok;

    assign st   = rail_state_e'(state);
    assign mode = mon_sel_e'(sel);

    always_comb begin
        volt_ok = !uv && !(win && ov);
        cur_ok  = (mode == MON_VOLT) || !ilim;
        if (mode == MON_NONE) begin
            good = 1'b1;
        end else if (st == RS_FAULT_OFF && irq) begin
            good = 1'b0;
        end else if (!en) begin
            good = 1'b1;
        end else begin
            unique case (st)
                RS_REGULATE:  good = volt_ok && cur_ok;
                RS_SHUT_DLY,
                RS_RAMP_DOWN,
                RS_FAULT_OFF: good = 1'b1;
                default:      good = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pg_debounce.sv
module pg_debounce #(
    parameter int FALL_CYC   = 14,
    parameter int RISE_SHORT = 4,
    parameter int RISE_LONG  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic long_sel,
    output logic filt
);
    localparam int MAX_LIM = (FALL_CYC > RISE_LONG) ?
                             ((FALL_CYC > RISE_SHORT) ? FALL_CYC : RISE_SHORT) :
                             ((RISE_LONG > RISE_SHORT) ? RISE_LONG : RISE_SHORT);
    localparam int CW = $clog2(MAX_LIM + 1);
    localparam logic [CW:0] LIM_FALL  = (CW+1)'(FALL_CYC);
    localparam logic [CW:0] LIM_SHORT = (CW+1)'(RISE_SHORT);
    localparam logic [CW:0] LIM_LONG  = (CW+1)'(RISE_LONG);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } dbc_t;

    dbc_t        q, d;
    logic [CW:0] nxt;
    logic [CW:0] lim;

    always_comb begin
        d   = q;
        nxt = {1'b0, q.cnt} + {{CW{1'b0}}, 1'b1};
        lim = raw ? (long_sel ? LIM_LONG : LIM_SHORT) : LIM_FALL;
        if (raw == q.filt) begin
            d.cnt = '0;
        end else if (nxt >= lim) begin
            d.filt = raw;
            d.cnt  = '0;
        end else begin
            d.cnt = nxt[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.filt <= 1'b1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign filt = q.filt;
endmodule

// File: rtl/pg_drive.sv
module pg_drive (
    input  logic active,
    input  logic pol,
    input  logic od,
    output logic pin,
    output logic oe
);
    logic level;

    always_comb begin
        level = pol ? active : !active;
        if (od) begin
            pin = 1'b0;
            oe  = !level;
        end else begin
            pin = level;
            oe  = 1'b1;
        end
    end
endmodule

// File: rtl/pg_aggregator.sv
module pg_aggregator #(
    parameter int N_RAIL     = 4,
    parameter int FALL_CYC   = 14,
    parameter int RISE_SHORT = 4,
    parameter int RISE_LONG  = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_RAIL-1:0]      rail_en,
    input  logic [N_RAIL-1:0][2:0] rail_state,
    input  logic [N_RAIL-1:0][1:0] mon_sel,
    input  logic [N_RAIL-1:0]      uv_flag,
    input  logic [N_RAIL-1:0]      ov_flag,
    input  logic [N_RAIL-1:0]      ilim_flag,
    input  logic [N_RAIL-1:0]      irq_pend,
    input  logic                   cfg_window,
    input  logic                   cfg_pol,
    input  logic                   cfg_od,
    input  logic                   cfg_long_dly,
    input  logic                   cfg_sticky,
    input  logic                   flt_rd,
    output logic [N_RAIL-1:0]      flt_bits,
    output logic                   pg_pin,
    output logic                   pg_oe
);
    typedef struct packed {
        logic [N_RAIL-1:0] flt;
    } agg_t;

    logic [N_RAIL-1:0] raw_good;
    logic [N_RAIL-1:0] filt_good;
    agg_t              q, d;
    logic              active;

    for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
        pg_rail_qual u_qual (
            .en    (rail_en[i]),
            .state (rail_state[i]),
            .sel   (mon_sel[i]),
            .uv    (uv_flag[i]),
            .ov    (ov_flag[i]),
            .ilim  (ilim_flag[i]),
            .irq   (irq_pend[i]),
            .win   (cfg_window),
            .good  (raw_good[i])
        );
        pg_debounce #(
            .FALL_CYC   (FALL_CYC),
            .RISE_SHORT (RISE_SHORT),
            .RISE_LONG  (RISE_LONG)
        ) u_dbc (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (raw_good[i]),
            .long_sel (cfg_long_dly),
            .filt     (filt_good[i])
        );
    end

    always_comb begin
        d = q;
        if (flt_rd) begin
            d.flt = ~filt_good;
        end else begin
            d.flt = q.flt | ~filt_good;
        end
        active = (&filt_good) && !(cfg_sticky && (|q.flt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.flt <= '0;
        end else begin
            q <= d;
        end
    end

    pg_drive u_drive (
        .active (active),
        .pol    (cfg_pol),
        .od     (cfg_od),
        .pin    (pg_pin),
        .oe     (pg_oe)
    );

    assign flt_bits = q.flt;
endmodule

// File: rtl/pg_aggregator_chk.sv
module pg_aggregator_chk #(
    parameter int N_RAIL = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_RAIL-1:0] raw,
    input logic [N_RAIL-1:0] filt,
    input logic [N_RAIL-1:0] flt_bits,
    input logic              flt_rd,
    input logic              cfg_sticky,
    input logic              cfg_pol,
    input logic              cfg_od,
    input logic              pg_pin,
    input logic              pg_oe
);
    logic seen;
    assign seen = pg_oe ? pg_pin : 1'b1;

    for (genvar i = 0; i < N_RAIL; i++) begin : g_chk
        AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            !filt[i] |=> flt_bits[i]); // R8
        AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!flt_rd && flt_bits[i]) |=> flt_bits[i]); // R8
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_rd && filt[i]) |=> !flt_bits[i]); // R9
        AST_RISE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(filt[i]) |-> $past(raw[i])); // R7
        AST_FALL_NEEDS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(filt[i]) |-> !$past(raw[i])); // R6
    end

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_od && pg_oe) |-> !pg_pin); // R11
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sticky && (|flt_bits)) |-> (seen != cfg_pol)); // R10
    AST_ANY_BAD_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(&filt) |-> (seen != cfg_pol)); // R5
endmodule

bind pg_aggregator pg_aggregator_chk #(.N_RAIL(N_RAIL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw        (raw_good),
    .filt       (filt_good),
    .flt_bits   (flt_bits),
    .flt_rd     (flt_rd),
    .cfg_sticky (cfg_sticky),
    .cfg_pol    (cfg_pol),
    .cfg_od     (cfg_od),
    .pg_pin     (pg_pin),
    .pg_oe      (pg_oe)
);

// File: tb/pg_aggregator_bench.sv
module pg_aggregator_bench;
    localparam int NR = 4;
    localparam int FC = 6;
    localparam int RS = 3;
    localparam int RL = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NR-1:0]       rail_en;
    logic [NR-1:0][2:0]  rail_state;
    logic [NR-1:0][1:0]  mon_sel;
    logic [NR-1:0]       uv_flag, ov_flag, ilim_flag, irq_pend;
    logic                cfg_window, cfg_pol, cfg_od, cfg_long_dly, cfg_sticky, flt_rd;
    logic [NR-1:0]       flt_bits;
    logic                pg_pin, pg_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit m_filt [NR];
    int m_cnt  [NR];
    bit m_flt  [NR];

    always #2.5 clk = ~clk;

    pg_aggregator #(.N_RAIL(NR), .FALL_CYC(FC), .RISE_SHORT(RS), .RISE_LONG(RL)) u_pg_aggregator (
        .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .rail_state(rail_state),
        .mon_sel(mon_sel), .uv_flag(uv_flag), .ov_flag(ov_flag), .ilim_flag(ilim_flag),
        .irq_pend(irq_pend), .cfg_window(cfg_window), .cfg_pol(cfg_pol), .cfg_od(cfg_od),
        .cfg_long_dly(cfg_long_dly), .cfg_sticky(cfg_sticky), .flt_rd(flt_rd),
        .flt_bits(flt_bits), .pg_pin(pg_pin), .pg_oe(pg_oe)
    );

    // Raw verdict of one rail, from R1-style mode codes, window, state table and masking rules
    function automatic bit raw_ok(int i);
        bit vok, cok;
        if (mon_sel[i] == 2'd0) return 1'b1;
        if (rail_state[i] == 3'd7 && irq_pend[i]) return 1'b0;
        if (!rail_en[i]) return 1'b1;
        vok = !uv_flag[i] && !(cfg_window && ov_flag[i]);
        cok = (mon_sel[i] == 2'd1) || !ilim_flag[i];
        case (rail_state[i])
            3'd3:             return vok && cok;
            3'd5, 3'd6, 3'd7: return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                m_filt[i] = 1'b1; m_cnt[i] = 0; m_flt[i] = 1'b0;
            end
        end else begin
            for (int i = 0; i < NR; i++) begin
                bit r;
                int lim;
                m_flt[i] = flt_rd ? !m_filt[i] : (m_flt[i] || !m_filt[i]);
                r = raw_ok(i);
                if (r == m_filt[i]) m_cnt[i] = 0;
                else begin
                    lim = r ? (cfg_long_dly ? RL : RS) : FC;
                    if (m_cnt[i] + 1 >= lim) begin m_filt[i] = r; m_cnt[i] = 0; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
        end
    end

    function automatic bit exp_active();
        bit all_ok = 1'b1, any_f = 1'b0;
        for (int i = 0; i < NR; i++) begin
            all_ok &= m_filt[i];
            any_f  |= m_flt[i];
        end
        return all_ok && !(cfg_sticky && any_f);
    endfunction

    task automatic cmp(string tag);
        bit lvl;
        logic [NR-1:0] ef;
        logic ep, eo;
        lvl = cfg_pol ? exp_active() : !exp_active();
        ep  = cfg_od ? 1'b0 : lvl;
        eo  = cfg_od ? !lvl : 1'b1;
        for (int i = 0; i < NR; i++) ef[i] = m_flt[i];
        checks++;
        if (pg_pin !== ep || pg_oe !== eo || flt_bits !== ef) begin
            errors++;
            $display("FAIL %s: pin/oe/flt actual %b/%b/%b expected %b/%b/%b",
                     tag, pg_pin, pg_oe, flt_bits, ep, eo, ef);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) begin
            tick();
            cmp(tag);
        end
    endtask

    task automatic read_faults(string tag);
        flt_rd = 1'b1;
        tick();
        flt_rd = 1'b0;
        cmp(tag);
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R12: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1357;
        void'($urandom(seed));
        rail_en = '1; mon_sel = {NR{2'd1}};
        for (int i = 0; i < NR; i++) rail_state[i] = 3'd3;
        uv_flag = '0; ov_flag = '0; ilim_flag = '0; irq_pend = '0;
        cfg_window = 1; cfg_pol = 1; cfg_od = 0; cfg_long_dly = 0; cfg_sticky = 0; flt_rd = 0;
        repeat (3) @(negedge clk);
        cmp("R12");
        rst_n = 1'b1;
        run(2, "R12");
        check_bit("R12", pg_pin, 1'b1);

        // R6: short undervoltage pulse is filtered, full-length one is not
        uv_flag[0] = 1; run(FC - 1, "R6");
        uv_flag[0] = 0; run(2, "R6");
        check_bit("R6", pg_pin, 1'b1);
        uv_flag[0] = 1; run(FC - 1, "R6");
        check_bit("R6", pg_pin, 1'b1);
        run(1, "R6");
        check_bit("R6", pg_pin, 1'b0);
        run(1, "R8");
        check_bit("R8", flt_bits[0], 1'b1);
        // R9: read while still bad keeps the bit
        read_faults("R9");
        check_bit("R9", flt_bits[0], 1'b1);
        // R7 short recovery
        uv_flag[0] = 0; run(RS - 1, "R7");
        check_bit("R7", pg_pin, 1'b0);
        run(1, "R7");
        check_bit("R7", pg_pin, 1'b1);
        run(3, "R8");
        read_faults("R9");
        check_bit("R9", flt_bits[0], 1'b0);

        // R2: overvoltage ignored with window 0
        cfg_window = 0; ov_flag[1] = 1; run(FC + 2, "R2");
        check_bit("R2", pg_pin, 1'b1);
        cfg_window = 1; run(FC, "R2");
        check_bit("R2", pg_pin, 1'b0);
        ov_flag[1] = 0; cfg_long_dly = 1; run(RL - 1, "R7");
        check_bit("R7", pg_pin, 1'b0);
        run(1, "R7");
        check_bit("R7", pg_pin, 1'b1);
        cfg_long_dly = 0; read_faults("R9");

        // R1: current limit under each mode
        ilim_flag[2] = 1; run(FC + 2, "R1");
        check_bit("R1", pg_pin, 1'b1);
        mon_sel[2] = 2'd2; run(FC, "R1");
        check_bit("R1", pg_pin, 1'b0);
        mon_sel[2] = 2'd3; run(2, "R1");
        mon_sel[2] = 2'd0; uv_flag[2] = 1; run(RS + 1, "R1");
        check_bit("R1", pg_pin, 1'b1);
        uv_flag[2] = 0; ilim_flag[2] = 0; mon_sel[2] = 2'd1; read_faults("R9");

        // R4: disabled rail masked; fault-disabled with pending interrupt is not
        rail_en[3] = 0; rail_state[3] = 3'd0; run(FC + 2, "R4");
        check_bit("R4", pg_pin, 1'b1);
        rail_state[3] = 3'd7; irq_pend[3] = 1; run(FC, "R4");
        check_bit("R4", pg_pin, 1'b0);
        irq_pend[3] = 0; run(RS + 1, "R4");
        rail_en[3] = 1; rail_state[3] = 3'd3; read_faults("R9");

        // R3: state table
        for (int s = 0; s < 8; s++) begin
            rail_state[0] = 3'(s); run(FC + RS + 1, "R3");
            check_bit("R3", pg_pin, (s == 3 || s >= 5) ? 1'b1 : 1'b0);
        end
        rail_state[0] = 3'd3; run(RS + 1, "R3"); read_faults("R9");

        // R10: sticky holds inactive until read
        cfg_sticky = 1; uv_flag[1] = 1; run(FC + 1, "R10");
        uv_flag[1] = 0; run(RS + 2, "R10");
        check_bit("R10", pg_pin, 1'b0);
        read_faults("R10");
        check_bit("R10", pg_pin, 1'b1);
        cfg_sticky = 0;

        // R11: polarity and drive type
        for (int c = 0; c < 4; c++) begin
            cfg_pol = c[0]; cfg_od = c[1]; run(1, "R11");
            uv_flag[2] = 1; run(FC, "R11");
            uv_flag[2] = 0; run(RS, "R11");
            read_faults("R11");
        end
        cfg_pol = 1; cfg_od = 0;

        // R5: random mix against the cycle model
        for (int n = 0; n < 6000; n++) begin
            if ($urandom % 6 == 0) begin
                int r;
                r = int'($urandom % NR);
                case ($urandom % 8)
                    0: rail_en[r] = 1'($urandom);
                    1: rail_state[r] = ($urandom % 2) ? 3'd3 : 3'($urandom);
                    2: mon_sel[r] = 2'($urandom);
                    3: uv_flag[r] = ($urandom % 3 == 0);
                    4: ov_flag[r] = ($urandom % 3 == 0);
                    5: ilim_flag[r] = ($urandom % 3 == 0);
                    6: irq_pend[r] = ($urandom % 3 == 0);
                    default: rail_state[r] = 3'd3;
                endcase
            end
            if ($urandom % 64 == 0) begin
                cfg_window = 1'($urandom); cfg_pol = 1'($urandom); cfg_od = 1'($urandom);
                cfg_long_dly = 1'($urandom); cfg_sticky = 1'($urandom);
            end
            flt_rd = ($urandom % 24 == 0);
            tick();
            cmp("R5");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule